// File: doc/BRIEF.md
# Branch Prediction Accuracy Counters

This block sits beside a branch predictor and watches its update port. Each time a conditional branch resolves, the pipeline raises an update strobe together with the branch's real outcome, a flag saying whether the branch jumps backward or forward, and the prediction that fetch originally made for it. The block counts these resolved branches and the correctly predicted ones. It keeps one pair of counts for forward branches, one pair for backward branches and one pair for all branches.

The six counts are plain registered outputs and can be read on any cycle. A synchronous clear input resets them all at once, for example at the start of a measurement window. Every counter stops at its maximum value rather than wrapping, so a long run never reports a falsely small figure. Turning the counts into percentages is left to whatever reads them.

Top module: `bpa_accuracy_counters`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all six counters are zero after that edge.
- R2: A cycle with `upd_valid` low and `clr` low leaves every counter unchanged.
- R3: An update with `upd_backward` = 0 (forward branch) adds one to `fwd_total` and to `all_total` and leaves `bwd_total` and `bwd_correct` unchanged.
- R4: An update with `upd_backward` = 1 (backward branch, target below the branch address) adds one to `bwd_total` and to `all_total` and leaves `fwd_total` and `fwd_correct` unchanged.
- R5: An update is correct when `upd_pred` equals `upd_taken`. A correct update adds one to `all_correct` and to the correct counter of its direction. An incorrect update changes no correct counter.
- R6: A counter that holds 2^CNT_W-1 stays at that value when it would otherwise increment.
- R7: `clr` high at a clock edge zeroes all six counters after that edge. When an update arrives in the same cycle, the clear wins and the update is dropped.
- R8: While none of `fwd_total`, `bwd_total` and `all_total` is saturated, `all_total` equals `fwd_total + bwd_total`. The same relation holds between `all_correct` and the two per-direction correct counters.
- R9: Each correct counter never exceeds the total counter of its own class.
- R10: A counter's new value is visible on the output in the cycle after the edge that captured the update. The block adds no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters, overrides updates |
| upd_valid | input | 1 | Update strobe: a conditional branch has resolved this cycle |
| upd_taken | input | 1 | True outcome, 1 = taken |
| upd_backward | input | 1 | Direction, 1 = backward, 0 = forward |
| upd_pred | input | 1 | Prediction originally made, 1 = taken |
| fwd_total | output | CNT_W | Resolved forward branches |
| fwd_correct | output | CNT_W | Correctly predicted forward branches |
| bwd_total | output | CNT_W | Resolved backward branches |
| bwd_correct | output | CNT_W | Correctly predicted backward branches |
| all_total | output | CNT_W | Resolved branches of both directions |
| all_correct | output | CNT_W | Correctly predicted branches of both directions |

## Verification
Some properties are checked on every cycle: counts hold on idle cycles, a clear wins, saturated counters stick, each correct count stays at or below its total, and the overall counts equal the sum of the two directions until saturation breaks that sum. Per-direction increments and stability on mispredicts are also checked each cycle. The bench shows the rest through directed and random scenarios: exact counts after mixed streams of forward and backward branches, a clear that collides with an update, and counters driven into saturation at a narrow width.

// File: rtl/bpa_pkg.sv
`timescale 1ns/1ps
// Package bpa_pkg
// Shared indices and types for the branch accuracy counters.
// Assumes six counters, ordered as listed in the counter index enum.
package bpa_pkg;

    // Direction encoding carried by the update port
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_BWD = 1'b1
    } bpa_dir_e;

    localparam int NUM_CNT = 6;

    // Counter slot numbering used by decode and the top
    localparam int IDX_FWD_TOT = 0;
    localparam int IDX_FWD_HIT = 1;
    localparam int IDX_BWD_TOT = 2;
    localparam int IDX_BWD_HIT = 3;
    localparam int IDX_ALL_TOT = 4;
    localparam int IDX_ALL_HIT = 5;

    // One update event as seen at the predictor update port
    typedef struct packed {
        logic     valid;
        logic     taken;
        bpa_dir_e dir;
        logic     pred;
    } bpa_event_t;

endpackage

// File: rtl/bpa_event_decode.sv
`timescale 1ns/1ps
// Module bpa_event_decode
// Turns one update event into one increment enable per counter.
// Purely combinational. Assumes the event fields are stable around the edge.
module bpa_event_decode
    import bpa_pkg::*;
(
    input  bpa_event_t         ev,
    output logic [NUM_CNT-1:0] inc
);

    logic hit;
    logic is_bwd;

    // Classify the event: correct prediction and direction
    always_comb begin
        hit    = (ev.pred == ev.taken);
        is_bwd = (ev.dir == DIR_BWD);
    end

    // Raise the enables of every counter this event belongs to
    always_comb begin
        inc              = '0;
        inc[IDX_FWD_TOT] = ev.valid && !is_bwd;
        inc[IDX_FWD_HIT] = ev.valid && !is_bwd && hit;
        inc[IDX_BWD_TOT] = ev.valid && is_bwd;
        inc[IDX_BWD_HIT] = ev.valid && is_bwd && hit;
        inc[IDX_ALL_TOT] = ev.valid;
        inc[IDX_ALL_HIT] = ev.valid && hit;
    end

endmodule

// File: rtl/bpa_sat_counter.sv
`timescale 1ns/1ps
// Module bpa_sat_counter
// Up-counter that sticks at its all-ones value.
// Synchronous active-low reset. A clear overrides the increment.
module bpa_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    logic at_max;

    // Detect the saturation point
    always_comb at_max = (cnt == MAX_VAL);

    // Reset, clear, or count up while below the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && !at_max)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/bpa_accuracy_counters.sv
`timescale 1ns/1ps
// Module bpa_accuracy_counters (top)
// Counts resolved conditional branches and correct predictions, split
// into forward, backward and combined classes.
// Assumes at most one update per cycle. Outputs are the counter registers.
module bpa_accuracy_counters
    import bpa_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic             upd_backward,
    input  logic             upd_pred,
    output logic [CNT_W-1:0] fwd_total,
    output logic [CNT_W-1:0] fwd_correct,
    output logic [CNT_W-1:0] bwd_total,
    output logic [CNT_W-1:0] bwd_correct,
    output logic [CNT_W-1:0] all_total,
    output logic [CNT_W-1:0] all_correct
);

    bpa_event_t         ev;
    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    // Pack the update port into one event record
    always_comb begin
        ev.valid = upd_valid;
        ev.taken = upd_taken;
        ev.dir   = bpa_dir_e'(upd_backward);
        ev.pred  = upd_pred;
    end

    bpa_event_decode u_dec (
        .ev  (ev),
        .inc (inc)
    );

    // One saturating counter per class
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        bpa_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[g]),
            .cnt   (cnt_q[g])
        );
    end

    // Route counter registers to the named outputs
    always_comb begin
        fwd_total   = cnt_q[IDX_FWD_TOT];
        fwd_correct = cnt_q[IDX_FWD_HIT];
        bwd_total   = cnt_q[IDX_BWD_TOT];
        bwd_correct = cnt_q[IDX_BWD_HIT];
        all_total   = cnt_q[IDX_ALL_TOT];
        all_correct = cnt_q[IDX_ALL_HIT];
    end

endmodule

// File: rtl/bpa_accuracy_checker.sv
`timescale 1ns/1ps
// Module bpa_accuracy_checker
// Cycle-level properties of the accuracy counters, bound to the top.
module bpa_accuracy_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic             upd_backward,
    input logic             upd_pred,
    input logic [CNT_W-1:0] fwd_total,
    input logic [CNT_W-1:0] fwd_correct,
    input logic [CNT_W-1:0] bwd_total,
    input logic [CNT_W-1:0] bwd_correct,
    input logic [CNT_W-1:0] all_total,
    input logic [CNT_W-1:0] all_correct
);

    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (all_total == '0 && all_correct == '0 && fwd_total == '0 &&
                    bwd_total == '0 && fwd_correct == '0 && bwd_correct == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !clr) |=> ($stable(all_total) && $stable(all_correct) &&
            $stable(fwd_total) && $stable(bwd_total) &&
            $stable(fwd_correct) && $stable(bwd_correct)));

    p_fwd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !clr && !upd_backward && fwd_total != MAX_VAL) |=>
            (fwd_total == $past(fwd_total) + 1'b1 && $stable(bwd_total) &&
             $stable(bwd_correct)));

    p_bwd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !clr && upd_backward && bwd_total != MAX_VAL) |=>
            (bwd_total == $past(bwd_total) + 1'b1 && $stable(fwd_total) &&
             $stable(fwd_correct)));

    p_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !clr && (upd_pred != upd_taken)) |=>
            ($stable(all_correct) && $stable(fwd_correct) && $stable(bwd_correct)));

    p_sat_stick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_total == MAX_VAL && !clr) |=> (all_total == MAX_VAL));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (all_total == '0 && all_correct == '0 && fwd_total == '0 &&
                 bwd_total == '0 && fwd_correct == '0 && bwd_correct == '0));

    p_sum_total_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_total != MAX_VAL && bwd_total != MAX_VAL && all_total != MAX_VAL) |->
            ({1'b0, all_total} == {1'b0, fwd_total} + {1'b0, bwd_total}));

    p_hit_le_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_correct <= fwd_total && bwd_correct <= bwd_total &&
         all_correct <= all_total));

endmodule

bind bpa_accuracy_counters bpa_accuracy_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .upd_valid    (upd_valid),
    .upd_taken    (upd_taken),
    .upd_backward (upd_backward),
    .upd_pred     (upd_pred),
    .fwd_total    (fwd_total),
    .fwd_correct  (fwd_correct),
    .bwd_total    (bwd_total),
    .bwd_correct  (bwd_correct),
    .all_total    (all_total),
    .all_correct  (all_correct)
);

// File: tb/sim_bpa_accuracy_counters.sv
`timescale 1ns/1ps
// Bench for bpa_accuracy_counters: behavioural model compared every cycle.
module sim_bpa_accuracy_counters;

    localparam int W   = 5;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic upd_valid = 1'b0;
    logic upd_taken = 1'b0;
    logic upd_backward = 1'b0;
    logic upd_pred = 1'b0;
    logic [W-1:0] fwd_total, fwd_correct, bwd_total, bwd_correct, all_total, all_correct;

    int checks = 0;
    int errors = 0;
    // model: 0 fwd tot, 1 fwd hit, 2 bwd tot, 3 bwd hit, 4 all tot, 5 all hit
    int m [6];

    always #2 clk = ~clk;

    bpa_accuracy_counters #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .upd_valid(upd_valid),
        .upd_taken(upd_taken), .upd_backward(upd_backward), .upd_pred(upd_pred),
        .fwd_total(fwd_total), .fwd_correct(fwd_correct),
        .bwd_total(bwd_total), .bwd_correct(bwd_correct),
        .all_total(all_total), .all_correct(all_correct)
    );

    function automatic int bump(int v);
        return (v >= MAX) ? MAX : v + 1;
    endfunction

    task automatic chk1(string tag, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk1(tag, "fwd_total",   int'(fwd_total),   m[0]);
        chk1(tag, "fwd_correct", int'(fwd_correct), m[1]);
        chk1(tag, "bwd_total",   int'(bwd_total),   m[2]);
        chk1(tag, "bwd_correct", int'(bwd_correct), m[3]);
        chk1(tag, "all_total",   int'(all_total),   m[4]);
        chk1(tag, "all_correct", int'(all_correct), m[5]);
    endtask

    // Drive one cycle, advance the model at the edge, compare at the next falling edge (R10)
    task automatic step(logic v, logic t, logic b, logic p, logic c, string tag);
        upd_valid = v; upd_taken = t; upd_backward = b; upd_pred = p; clr = c;
        @(posedge clk);
        if (c) begin
            foreach (m[i]) m[i] = 0;
        end else if (v) begin
            if (b) begin
                m[2] = bump(m[2]);
                if (p == t) m[3] = bump(m[3]);
            end else begin
                m[0] = bump(m[0]);
                if (p == t) m[1] = bump(m[1]);
            end
            m[4] = bump(m[4]);
            if (p == t) m[5] = bump(m[5]);
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        foreach (m[i]) m[i] = 0;
        // R1: reset dominates an active update
        upd_valid = 1'b1;
        repeat (3) @(negedge clk);
        compare_all("R1");
        upd_valid = 1'b0;
        rst_n = 1'b1;

        // R2: idle cycles hold zero
        repeat (3) step(0, 1, 0, 1, 0, "R2");
        // R3: forward, correct and incorrect
        step(1, 1, 0, 1, 0, "R3");
        step(1, 0, 0, 1, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        // R4: backward, correct and incorrect
        step(1, 1, 1, 1, 0, "R4");
        step(1, 1, 1, 0, 0, "R4");
        // R5: mispredicts of each sense, then correct not-taken
        step(1, 1, 0, 0, 0, "R5");
        step(1, 0, 1, 1, 0, "R5");
        step(1, 0, 1, 0, 0, "R5");
        // R2: idle after activity holds values
        repeat (2) step(0, 0, 1, 0, 0, "R2");
        // R8 and R9 relations at this point
        checks++;
        if (int'(all_total) != int'(fwd_total) + int'(bwd_total)) begin
            errors++;
            $display("FAIL R8 all_total actual=%0d expected=%0d", all_total, fwd_total + bwd_total);
        end
        checks++;
        if (fwd_correct > fwd_total || bwd_correct > bwd_total) begin
            errors++;
            $display("FAIL R9 correct>total actual=%0d/%0d expected<=%0d/%0d",
                     fwd_correct, bwd_correct, fwd_total, bwd_total);
        end
        // R7: clear alone, then clear colliding with an update
        step(0, 0, 0, 0, 1, "R7");
        step(1, 1, 0, 1, 0, "R7");
        step(1, 1, 1, 1, 1, "R7");
        // R6: drive forward counters past saturation
        for (int i = 0; i < MAX + 6; i++) step(1, 1, 0, 1, 0, "R6");
        // R6: backward counters too; all_total already stuck
        for (int i = 0; i < MAX + 3; i++) step(1, 0, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 1, "R7");
        // Random mix with occasional clears
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                 ($urandom % 50) == 0, "R5");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule